// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns a parallel data word, taken once per word period, into a serial frame of twelve bits sent one per bit clock. The bit clock runs at twelve times the word rate. A one-cycle word strobe marks the first bit of each frame. Each data word is wrapped between a forced high start bit and a forced low stop bit. The receiver can then recover timing from the rising edge at every frame start.

The transmitter goes through three modes. After reset or power-down it waits for a lock interval and does not drive its output. It then sends either data frames or a training burst. The training burst helps a receiver align, and the transmitter sends one when either of two sync request inputs has been held for six word periods. Once a burst starts it cannot be cut short. It keeps going past its minimum length for as long as the request stays high. An output-enable input only gates the driver. Internal sequencing carries on while the output is disabled. A select input chooses whether the parallel word is taken at the start of the word period or half a period later.

Top module: `frame_serializer`

## Requirements
- R1: Each data frame is 12 bits, sent from the bit after a word strobe. Bit 0 is a high start bit. Bits 1 to 10 carry the data word, least significant bit first. Bit 11 is a low stop bit.
- R2: With `cap_rise` high, the word is captured in the strobe cycle. With `cap_rise` low, it is captured six bit periods after the strobe. The captured word is sent in the frame that begins at the next strobe.
- R3: A training frame carries ones in bits 0 to 5 and zeros in bits 6 to 11. As a 12-bit value, with bit 0 sent first, it is 12'h03F.
- R4: The request is the OR of `sync_req_a` and `sync_req_b`, sampled at each strobe. The first training frame is the one loaded at the sixth consecutive strobe that sees the request high. Five such strobes are not enough to start a burst.
- R5: A burst sends at least 1024 training frames, even if the request is dropped or toggled before then. Parallel data presented during the burst is never sent. After the burst, the word captured at the last training strobe is sent.
- R6: If the request is still high at the strobe that follows the 1024th training frame, training frames continue. The first data frame is loaded at the first strobe that sees the request low.
- R7: After reset is released, `locked` and `ser_drive` stay low through 2047 strobes. Both become high at the 2048th strobe, and that strobe loads the first frame.
- R8: With `out_en` low, `ser_drive` and `ser_out` are low. The burst count still advances, so disabling the output does not lengthen a burst.
- R9: Low `pwrdn_n` forces `ser_drive` low at once and clears `locked` at the next clock edge. After release, the full 2048-strobe lock interval of R7 is repeated.
- R10: Mode changes take effect only at a strobe. Every frame seen at the output is therefore a complete data frame or a complete training frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve cycles per word period |
| rst_n | input | 1 | Synchronous active-low reset |
| word_tick | input | 1 | One-cycle strobe marking the start of each word period |
| data_in | input | 10 | Parallel data word |
| sync_req_a | input | 1 | Training request, first source |
| sync_req_b | input | 1 | Training request, second source |
| out_en | input | 1 | Output driver enable |
| pwrdn_n | input | 1 | Active-low power-down |
| cap_rise | input | 1 | 1: capture at strobe, 0: capture at half period |
| ser_out | output | 1 | Serial bit, forced low when not driven |
| ser_drive | output | 1 | Output is being driven (stands in for leaving high impedance) |
| locked | output | 1 | Lock interval complete |

## Verification
Two events can fall on the same strobe: the end of the minimum burst and the request check. At the strobe after the 1024th training frame, the block must decide whether to extend the burst or return to data. The bench holds one request through exactly 1025 training frames and drops it just before the next strobe. It then expects exactly 1025 training frames followed by a complete data frame. A second burst releases the request early and keeps the output disabled for 200 of its frames. For that burst the bench expects exactly 1024 training frames, with a zero driver flag throughout the disabled window.

// File: rtl/fser_pkg.sv
// Shared types for the framed serial transmitter.
// Assumes: nothing beyond the enum below is shared between modules.
package fser_pkg;

    // Transmit mode; updated only at word strobes or by a clear.
    typedef enum logic [1:0] {
        MODE_INIT  = 2'd0,
        MODE_TRAIN = 2'd1,
        MODE_DATA  = 2'd2
    } fser_mode_e;

endpackage

// File: rtl/fser_word_capture.sv
// Parallel word capture with a selectable capture point.
// Tracks the bit phase inside the word period from the strobe. It captures
// the input either in the strobe cycle or half a word period later.
// Assumes: word_tick arrives once every FRAME_BITS cycles.
module fser_word_capture #(
    parameter int WORD_W     = 10,
    parameter int FRAME_BITS = WORD_W + 2,
    localparam int PH_W      = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_tick,
    input  logic              cap_rise,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] word_q
);

    localparam logic [PH_W-1:0] LAST_PH = PH_W'(FRAME_BITS - 1);
    localparam logic [PH_W-1:0] MID_PH  = PH_W'(FRAME_BITS / 2 - 1);

    logic [PH_W-1:0] phase_q;
    logic            cap_now;

    // Bit phase since the last strobe, saturating at the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (word_tick) begin
            phase_q <= '0;
        end else if (phase_q != LAST_PH) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Capture point: the strobe itself, or the half-period edge.
    always_comb begin
        if (cap_rise) begin
            cap_now = word_tick;
        end else begin
            cap_now = !word_tick && (phase_q == MID_PH);
        end
    end

    // Hold register for the word that goes into the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (cap_now) begin
            word_q <= data_in;
        end
    end

endmodule

// File: rtl/fser_sync_filter.sv
// Training-request qualifier.
// ORs the two request sources. It counts consecutive strobes at which the
// combined request is high, and flags the request as qualified once
// REQ_WORDS consecutive strobes have seen it.
// Assumes: the request is only meaningful in strobe cycles.
module fser_sync_filter #(
    parameter int REQ_WORDS = 6,
    localparam int RUN_W    = $clog2(REQ_WORDS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn_n,
    input  logic word_tick,
    input  logic req_a,
    input  logic req_b,
    output logic req_now,
    output logic req_held
);

    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(REQ_WORDS - 1);

    logic [RUN_W-1:0] run_q;

    // Combined request level.
    always_comb req_now = req_a | req_b;

    // Qualified in the strobe that is the REQ_WORDS-th consecutive high one.
    always_comb req_held = req_now && (run_q == RUN_TOP);

    // Run length of consecutive high strobes, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwrdn_n) begin
            run_q <= '0;
        end else if (word_tick) begin
            if (!req_now) begin
                run_q <= '0;
            end else if (run_q != RUN_TOP) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fser_mode_ctrl.sv
// Mode sequencer: lock wait, training burst, data transmission.
// Counts strobes until lock, then picks training or data. It counts
// training frames so that a burst cannot end before BURST_FRAMES frames.
// Assumes: every state change happens at a strobe, except the clear from
// reset or power-down.
module fser_mode_ctrl
    import fser_pkg::*;
#(
    parameter int LOCK_WORDS   = 2048,
    parameter int BURST_FRAMES = 1024,
    localparam int LOCK_W      = $clog2(LOCK_WORDS + 1),
    localparam int BURST_W     = $clog2(BURST_FRAMES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwrdn_n,
    input  logic               word_tick,
    input  logic               req_now,
    input  logic               req_held,
    output fser_mode_e         mode_q,
    output fser_mode_e         next_mode,
    output logic               locked,
    output logic [BURST_W-1:0] burst_cnt
);

    localparam logic [LOCK_W-1:0]  LOCK_LAST = LOCK_W'(LOCK_WORDS - 1);
    localparam logic [BURST_W-1:0] BURST_MIN = BURST_W'(BURST_FRAMES);

    logic [LOCK_W-1:0] lock_cnt;
    logic              lock_done;
    logic              clear;
    logic              burst_met;

    // Synchronous clear from reset or power-down.
    always_comb clear = !rst_n || !pwrdn_n;

    // This strobe completes the lock interval.
    always_comb lock_done = (mode_q == MODE_INIT) && (lock_cnt == LOCK_LAST);

    // Minimum burst length has been sent.
    always_comb burst_met = (burst_cnt >= BURST_MIN);

    // Mode that the frame loaded at this strobe belongs to.
    always_comb begin
        next_mode = mode_q;
        case (mode_q)
            MODE_INIT:  if (lock_done) next_mode = req_held ? MODE_TRAIN : MODE_DATA;
            MODE_TRAIN: if (burst_met && !req_now) next_mode = MODE_DATA;
            MODE_DATA:  if (req_held) next_mode = MODE_TRAIN;
            default:    next_mode = MODE_INIT;
        endcase
    end

    // Mode register, advanced at strobes.
    always_ff @(posedge clk) begin
        if (clear) begin
            mode_q <= MODE_INIT;
        end else if (word_tick) begin
            mode_q <= next_mode;
        end
    end

    // Lock interval counter and lock flag.
    always_ff @(posedge clk) begin
        if (clear) begin
            lock_cnt <= '0;
            locked   <= 1'b0;
        end else if (word_tick && mode_q == MODE_INIT) begin
            if (lock_done) begin
                locked <= 1'b1;
            end else begin
                lock_cnt <= lock_cnt + 1'b1;
            end
        end
    end

    // Training frame count: 1 on entry, climbing to the minimum.
    always_ff @(posedge clk) begin
        if (clear) begin
            burst_cnt <= '0;
        end else if (word_tick) begin
            if (next_mode == MODE_TRAIN && mode_q != MODE_TRAIN) begin
                burst_cnt <= BURST_W'(1);
            end else if (mode_q == MODE_TRAIN && !burst_met) begin
                burst_cnt <= burst_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fser_frame_shifter.sv
// Frame builder and shift register.
// At each strobe it loads a full frame for the coming mode, then shifts it
// out one bit per clock, bit 0 first.
// Assumes: the strobe period equals FRAME_BITS, so each frame ends exactly
// before the next load.
module fser_frame_shifter
    import fser_pkg::*;
#(
    parameter int WORD_W     = 10,
    parameter int FRAME_BITS = WORD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n,
    input  logic              word_tick,
    input  fser_mode_e        next_mode,
    input  logic [WORD_W-1:0] word_q,
    output logic              bit_out
);

    logic [FRAME_BITS-1:0] train_pat;
    logic [FRAME_BITS-1:0] frame_d;
    logic [FRAME_BITS-1:0] sh_q;

    // Training pattern: first half ones, second half zeros.
    for (genvar b = 0; b < FRAME_BITS; b++) begin : g_train
        assign train_pat[b] = (b < FRAME_BITS / 2);
    end

    // Frame contents for the mode taking effect at this strobe.
    always_comb begin
        case (next_mode)
            MODE_TRAIN: frame_d = train_pat;
            MODE_DATA:  frame_d = {1'b0, word_q, 1'b1};
            default:    frame_d = '0;
        endcase
    end

    // Load at the strobe, otherwise shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwrdn_n) begin
            sh_q <= '0;
        end else if (word_tick) begin
            sh_q <= frame_d;
        end else begin
            sh_q <= {1'b0, sh_q[FRAME_BITS-1:1]};
        end
    end

    // Current serial bit.
    always_comb bit_out = sh_q[0];

endmodule

// File: rtl/frame_serializer.sv
// Framed serial word transmitter, top level.
// Connects word capture, request qualification, mode sequencing and the
// frame shifter, and gates the serial output with lock, enable and power.
// Assumes: clk is the bit clock and word_tick pulses once per 12 bits.
module frame_serializer
    import fser_pkg::*;
#(
    parameter int WORD_W       = 10,
    parameter int LOCK_WORDS   = 2048,
    parameter int BURST_FRAMES = 1024,
    parameter int REQ_WORDS    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_tick,
    input  logic [WORD_W-1:0] data_in,
    input  logic              sync_req_a,
    input  logic              sync_req_b,
    input  logic              out_en,
    input  logic              pwrdn_n,
    input  logic              cap_rise,
    output logic              ser_out,
    output logic              ser_drive,
    output logic              locked
);

    localparam int FRAME_BITS = WORD_W + 2;
    localparam int BURST_W    = $clog2(BURST_FRAMES + 1);

    logic [WORD_W-1:0]  word_q;
    logic               req_now;
    logic               req_held;
    fser_mode_e         mode_q;
    fser_mode_e         next_mode;
    logic [BURST_W-1:0] burst_cnt;
    logic               bit_out;

    fser_word_capture #(
        .WORD_W     (WORD_W),
        .FRAME_BITS (FRAME_BITS)
    ) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_tick (word_tick),
        .cap_rise  (cap_rise),
        .data_in   (data_in),
        .word_q    (word_q)
    );

    fser_sync_filter #(
        .REQ_WORDS (REQ_WORDS)
    ) req_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrdn_n   (pwrdn_n),
        .word_tick (word_tick),
        .req_a     (sync_req_a),
        .req_b     (sync_req_b),
        .req_now   (req_now),
        .req_held  (req_held)
    );

    fser_mode_ctrl #(
        .LOCK_WORDS   (LOCK_WORDS),
        .BURST_FRAMES (BURST_FRAMES)
    ) mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrdn_n   (pwrdn_n),
        .word_tick (word_tick),
        .req_now   (req_now),
        .req_held  (req_held),
        .mode_q    (mode_q),
        .next_mode (next_mode),
        .locked    (locked),
        .burst_cnt (burst_cnt)
    );

    fser_frame_shifter #(
        .WORD_W     (WORD_W),
        .FRAME_BITS (FRAME_BITS)
    ) shf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrdn_n   (pwrdn_n),
        .word_tick (word_tick),
        .next_mode (next_mode),
        .word_q    (word_q),
        .bit_out   (bit_out)
    );

    // Driver gating: locked, enabled and powered.
    always_comb ser_drive = locked && out_en && pwrdn_n;

    // Serial bit forced low while undriven.
    always_comb ser_out = ser_drive && bit_out;

endmodule

// File: rtl/fser_chk.sv
// Property checker for the framed serial transmitter, bound to the top.
// Keeps its own strobe phase and strobe count so that frame edges and the
// lock interval are judged independently of the design counters.
module fser_chk
    import fser_pkg::*;
#(
    parameter int LOCK_WORDS   = 2048,
    parameter int BURST_FRAMES = 1024,
    parameter int FRAME_BITS   = 12,
    localparam int PH_W        = $clog2(FRAME_BITS),
    localparam int LK_W        = $clog2(LOCK_WORDS + 1),
    localparam int BURST_W     = $clog2(BURST_FRAMES + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               word_tick,
    input logic               out_en,
    input logic               pwrdn_n,
    input logic               ser_out,
    input logic               ser_drive,
    input logic               locked,
    input fser_mode_e         mode_q,
    input logic [BURST_W-1:0] burst_cnt
);

    logic            seen_q;
    logic [PH_W-1:0] ph_q;
    logic [LK_W-1:0] tk_cnt;

    // Checker view of the bit phase inside the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            ph_q   <= '0;
        end else if (word_tick) begin
            seen_q <= 1'b1;
            ph_q   <= '0;
        end else if (ph_q != PH_W'(FRAME_BITS - 1)) begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Strobes seen since the last clear, saturating at the lock interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwrdn_n) begin
            tk_cnt <= '0;
        end else if (word_tick && tk_cnt != LK_W'(LOCK_WORDS)) begin
            tk_cnt <= tk_cnt + 1'b1;
        end
    end

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && ph_q == '0 && ser_drive |-> ser_out);

    // R1
    stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && ph_q == PH_W'(FRAME_BITS - 1) && ser_drive |-> !ser_out);

    // R7
    lock_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> tk_cnt == LK_W'(LOCK_WORDS));

    // R7
    no_early_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tk_cnt < LK_W'(LOCK_WORDS) |-> !ser_drive);

    // R5
    burst_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_tick && mode_q == MODE_TRAIN && burst_cnt < BURST_W'(BURST_FRAMES)
        |=> mode_q == MODE_TRAIN);

    // R8
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !ser_drive && !ser_out);

    // R9
    pd_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> !locked);

    // R10
    mode_at_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_tick && pwrdn_n |=> $stable(mode_q));

endmodule

bind frame_serializer fser_chk #(
    .LOCK_WORDS   (LOCK_WORDS),
    .BURST_FRAMES (BURST_FRAMES),
    .FRAME_BITS   (FRAME_BITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_tick (word_tick),
    .out_en    (out_en),
    .pwrdn_n   (pwrdn_n),
    .ser_out   (ser_out),
    .ser_drive (ser_drive),
    .locked    (locked),
    .mode_q    (mode_q),
    .burst_cnt (burst_cnt)
);

// File: tb/frame_serializer_tb_top.sv
// Bench for the framed serial transmitter: a vector table of capture cases,
// then directed tests for lock, training bursts, enable and power-down.
module frame_serializer_tb_top;

    localparam int LOCK  = 2048;
    localparam int BURST = 1024;
    localparam logic [11:0] TRAIN = 12'h03F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_tick;
    logic [9:0] data_in = '0;
    logic       sync_req_a = 1'b0;
    logic       sync_req_b = 1'b0;
    logic       out_en = 1'b1;
    logic       pwrdn_n = 1'b1;
    logic       cap_rise = 1'b1;
    logic       ser_out;
    logic       ser_drive;
    logic       locked;

    int n_vec = 0;
    int n_bad = 0;
    int tk = 0;
    bit finished = 1'b0;

    // {cap_rise, word at strobe, word at half period, expected frame}
    localparam logic [32:0] VECS [8] = '{
        {1'b1, 10'h3FF, 10'h000, 12'h7FF},
        {1'b0, 10'h3FF, 10'h000, 12'h001},
        {1'b1, 10'h000, 10'h3FF, 12'h001},
        {1'b0, 10'h000, 10'h3FF, 12'h7FF},
        {1'b1, 10'h2AA, 10'h155, 12'h555},
        {1'b0, 10'h2AA, 10'h155, 12'h2AB},
        {1'b1, 10'h001, 10'h200, 12'h003},
        {1'b0, 10'h001, 10'h200, 12'h401}
    };

    frame_serializer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_tick  (word_tick),
        .data_in    (data_in),
        .sync_req_a (sync_req_a),
        .sync_req_b (sync_req_b),
        .out_en     (out_en),
        .pwrdn_n    (pwrdn_n),
        .cap_rise   (cap_rise),
        .ser_out    (ser_out),
        .ser_drive  (ser_drive),
        .locked     (locked)
    );

    always #4 clk = ~clk;

    // Word strobe every 12 bit clocks, updated away from the active edge.
    always @(negedge clk) tk <= (tk == 11) ? 0 : tk + 1;
    assign word_tick = (tk == 0);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Wait for the next strobe edge, then sample the 12 bits of its frame.
    task automatic grab(output logic [11:0] f, output logic [11:0] d);
        do @(posedge clk); while (word_tick !== 1'b1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            f[i] = ser_out;
            d[i] = ser_drive;
        end
    endtask

    // Count strobes from now and check the lock boundary.
    task automatic lock_wait(input string tag);
        for (int n = 0; n < LOCK - 1; n++) begin
            do @(posedge clk); while (word_tick !== 1'b1);
        end
        @(negedge clk);
        check({tag, " R7 locked before 2048th strobe"}, 32'(locked), 32'd0);
        check({tag, " R7 drive before 2048th strobe"}, 32'(ser_drive), 32'd0);
        do @(posedge clk); while (word_tick !== 1'b1);
        @(negedge clk);
        check({tag, " R7 locked at 2048th strobe"}, 32'(locked), 32'd1);
        check({tag, " R7 drive at 2048th strobe"}, 32'(ser_drive), 32'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [11:0] f;
        logic [11:0] d;
        int ntr;
        int odd;
        logic [11:0] last_f;
        bit done;

        // Reset state
        repeat (5) @(negedge clk);
        check("R7 reset locked", 32'(locked), 32'd0);
        check("R7 reset drive", 32'(ser_drive), 32'd0);
        check("R7 reset serial", 32'(ser_out), 32'd0);
        rst_n = 1'b1;
        lock_wait("reset");
        grab(f, d);

        // Vector table: capture point and frame layout
        for (int v = 0; v < 8; v++) begin
            cap_rise = VECS[v][32];
            data_in  = VECS[v][31:22];
            @(posedge clk);
            repeat (3) @(negedge clk);
            data_in = VECS[v][21:12];
            grab(f, d);
            check($sformatf("R1 R2 vector %0d frame", v), 32'(f), 32'(VECS[v][11:0]));
            check($sformatf("R1 vector %0d drive", v), 32'(d), 32'hFFF);
        end

        // Burst from request A, released early, output disabled for a while
        cap_rise = 1'b1;
        data_in = 10'h0F0;
        grab(f, d);
        sync_req_a = 1'b1;
        for (int k = 0; k < 5; k++) begin
            grab(f, d);
            check($sformatf("R4 data before sixth strobe %0d", k), 32'(f), 32'h1E1);
        end
        grab(f, d);
        check("R3 R4 R10 first training frame", 32'(f), 32'(TRAIN));
        sync_req_a = 1'b0;
        ntr = 1;
        odd = 0;
        done = 1'b0;
        last_f = '0;
        for (int j = 1; j < 1100 && !done; j++) begin
            if (j == 3) sync_req_b = 1'b1;
            if (j == 5) sync_req_b = 1'b0;
            if (j == 100) out_en = 1'b0;
            if (j == 300) out_en = 1'b1;
            data_in = (j < 1000) ? 10'(j) : 10'h2D2;
            grab(f, d);
            if (out_en == 1'b0) begin
                if (f !== 12'h000 || d !== 12'h000) odd++;
                ntr++;
            end else if (f == TRAIN && d == 12'hFFF) begin
                ntr++;
            end else begin
                last_f = f;
                done = 1'b1;
            end
        end
        check("R5 burst length after early release", 32'(ntr), 32'(BURST));
        check("R8 frames while output disabled", 32'(odd), 32'd0);
        check("R5 R10 first data frame after burst", 32'(last_f), 32'h5A5);

        // Burst from request B held past the minimum by one frame
        data_in = 10'h0F0;
        grab(f, d);
        sync_req_b = 1'b1;
        for (int k = 0; k < 5; k++) begin
            grab(f, d);
            check($sformatf("R4 data before sixth strobe B %0d", k), 32'(f), 32'h1E1);
        end
        grab(f, d);
        check("R3 R4 first training frame B", 32'(f), 32'(TRAIN));
        odd = 0;
        for (int j = 1; j < BURST + 1; j++) begin
            grab(f, d);
            if (f !== TRAIN) odd++;
        end
        check("R6 extended burst frames", 32'(odd), 32'd0);
        sync_req_b = 1'b0;
        grab(f, d);
        check("R6 R10 data after extension", 32'(f), 32'h1E1);

        // Power-down and re-lock
        pwrdn_n = 1'b0;
        #1;
        check("R9 drive drops at once", 32'(ser_drive), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R9 lock cleared", 32'(locked), 32'd0);
        repeat (30) @(negedge clk);
        pwrdn_n = 1'b1;
        lock_wait("powerdown");
        grab(f, d);
        check("R9 R1 frame after re-lock", 32'(f), 32'h1E1);

        finish_run();
    end

endmodule